// File: doc/BRIEF.md
# Lookup Table Access Port

This block gives software a register window onto an internal address lookup table. The table sits inside the block as an array of 96-bit entries whose count is a parameter. Software never addresses entries directly. It stages an entry in three 32-bit data registers and then issues a command through a table-control register. The command names an entry index, and bit 31 of the same write selects whether the staged words are committed to that entry or the entry is fetched into them.

The three data words hold an entry most-significant word first: the word at the lowest data offset carries entry bits 95:64, and the word at the highest data offset carries bits 31:0. A read-only identification register and a read-only size register describe the instance. A control bit wipes the 2-bit type field of every entry to the free code in a single cycle. The bus is a single-cycle request interface, and read data comes back one cycle after the request.

Top module: `lap_top`

## Requirements
- R1: Offset 0x00 reads {16'h0, VER_MAJOR[7:0], VER_MINOR[7:0]}, so the minor revision is in bits 7:0 and the major revision is in bits 15:8. Writes to it have no effect.
- R2: Offset 0x04 reads the table size in units of 1024 entries in bits 4:0, with zero in all other bits. A table of fewer than 1024 entries reports 0.
- R3: The data words at offsets 0x34, 0x38 and 0x3C each read back the last value written to them, until a fetch command reloads them.
- R4: A write to offset 0x20 with bit 31 set commits the data words into the entry whose index is in bits 30:0. Entry bit b is taken from data word (2 - b/32), at bit position b mod 32, where data word k sits at offset 0x34 + 4k.
- R5: A write to offset 0x20 with bit 31 clear fetches the indexed entry into the data words one cycle later, using the same word order as R4. A data-word read issued in the very next cycle already returns the fetched value.
- R6: An index of DEPTH or above is ignored by a commit, and no stored entry changes. The same index makes a fetch load all-zero data words.
- R7: Writing 1 to bit 30 of offset 0x08 sets the type field of every entry (entry bits 61:60, data word 1 bits 29:28) to 0 in one cycle and keeps all other entry bits. Offset 0x08 reads 0.
- R8: If a data-word write lands in the cycle in which a fetch loads the data words, the bus write wins for that word and the other two words take the fetched entry.
- R9: After reset, rvalid_o and rdata_o are 0, every data word reads 0, and every entry's type field is 0.
- R10: A read request returns its data on rdata_o with rvalid_o high exactly one cycle later, and rvalid_o is low in every other cycle. Offset 0x20 and any unmapped offset read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request, one access per cycle |
| we_i | input | 1 | 1 for a write access, 0 for a read access |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| rdata_o | output | 32 | Read data |

## Verification
A fetch loads the data words in the cycle after the table-control write, so the loading can collide with a bus access in that same cycle. The bench provokes this in two ways. It issues a data-word read immediately after a fetch command, and it expects the freshly fetched value through the forwarding path. It also issues a data-word write immediately after a fetch command, and it expects that word to hold the written value while its two neighbours hold the fetched entry. A single-cycle clear that coincides with a pending fetch is also covered: the entry is fetched after the clear, and the bench expects the type bits to be zero while every other bit is kept.

// File: rtl/lap_pkg.sv
package lap_pkg;
  localparam int WORD_W   = 32;
  localparam int NWORDS   = 3;
  localparam int ENTRY_W  = WORD_W * NWORDS;
  localparam int TYPE_LSB = 60;
  localparam int TYPE_W   = 2;
  localparam int PAY_W    = ENTRY_W - TYPE_W;
  localparam int IDX_FW   = 31;

  localparam logic [7:0] OFF_VER   = 8'h00;
  localparam logic [7:0] OFF_SIZE  = 8'h04;
  localparam logic [7:0] OFF_CTRL  = 8'h08;
  localparam logic [7:0] OFF_TCTL  = 8'h20;
  localparam logic [7:0] OFF_DATA0 = 8'h34;

  localparam int CLR_BIT    = 30;
  localparam int CMD_WR_BIT = 31;

  typedef logic [WORD_W-1:0]  word_t;
  typedef logic [ENTRY_W-1:0] entry_t;
  typedef logic [IDX_FW-1:0]  idx_t;
endpackage

// File: rtl/lap_table_store.sv
module lap_table_store
  import lap_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   wr_en_i,
  input  idx_t   wr_idx_i,
  input  entry_t wr_entry_i,
  input  idx_t   rd_idx_i,
  output entry_t rd_entry_o,
  input  logic   clr_i
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PAY_W-1:0]              pay_q [DEPTH];
  logic [DEPTH-1:0][TYPE_W-1:0]  type_q;

  logic wr_in, rd_in;
  logic [IDX_W-1:0] wr_a, rd_a;

  assign wr_in = wr_idx_i < IDX_FW'(DEPTH);
  assign rd_in = rd_idx_i < IDX_FW'(DEPTH);
  assign wr_a  = wr_idx_i[IDX_W-1:0];
  assign rd_a  = rd_idx_i[IDX_W-1:0];

  // payload: no reset, plain storage
  always_ff @(posedge clk_i) begin
    if (wr_en_i && wr_in)
      pay_q[wr_a] <= {wr_entry_i[ENTRY_W-1:TYPE_LSB+TYPE_W], wr_entry_i[TYPE_LSB-1:0]};
  end

  // type field kept in flops so a clear completes in one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      type_q <= '0;
    end else if (clr_i) begin
      type_q <= '0;
    end else if (wr_en_i && wr_in) begin
      type_q[wr_a] <= wr_entry_i[TYPE_LSB +: TYPE_W];
    end
  end

  always_comb begin
    rd_entry_o = '0;
    if (rd_in)
      rd_entry_o = {pay_q[rd_a][PAY_W-1:TYPE_LSB], type_q[rd_a], pay_q[rd_a][TYPE_LSB-1:0]};
  end

  a_r7_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (type_q == '0));

  a_r6_oob_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_in && !clr_i) |=> $stable(type_q));

  a_r6_oob_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_in |-> (rd_entry_o == '0));
endmodule

// File: rtl/lap_reg_if.sv
module lap_reg_if
  import lap_pkg::*;
#(
  parameter int         ADDR_W    = 8,
  parameter logic [7:0] VER_MAJOR = 8'h01,
  parameter logic [7:0] VER_MINOR = 8'h04,
  parameter logic [4:0] SIZE_CODE = 5'd0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  word_t             wdata_i,
  output logic              rvalid_o,
  output word_t             rdata_o,
  output logic              wr_en_o,
  output idx_t              wr_idx_o,
  output entry_t            wr_entry_o,
  output idx_t              rd_idx_o,
  input  entry_t            rd_entry_i,
  output logic              clr_o
);
  logic bus_wr, bus_rd, tctl_wr;
  logic ld_pend_q;
  idx_t rd_idx_q;
  logic [NWORDS-1:0] hit_data;
  word_t data_q [NWORDS];
  word_t view   [NWORDS];
  word_t rdata_d;
  logic  rvalid_q;
  word_t rdata_q;

  assign bus_wr  = req_i && we_i;
  assign bus_rd  = req_i && !we_i;
  assign tctl_wr = bus_wr && (addr_i == ADDR_W'(OFF_TCTL));

  assign wr_en_o  = tctl_wr && wdata_i[CMD_WR_BIT];
  assign wr_idx_o = wdata_i[IDX_FW-1:0];
  assign rd_idx_o = rd_idx_q;
  assign clr_o    = bus_wr && (addr_i == ADDR_W'(OFF_CTRL)) && wdata_i[CLR_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_pend_q <= 1'b0;
      rd_idx_q  <= '0;
    end else begin
      ld_pend_q <= tctl_wr && !wdata_i[CMD_WR_BIT];
      if (tctl_wr && !wdata_i[CMD_WR_BIT]) rd_idx_q <= wdata_i[IDX_FW-1:0];
    end
  end

  for (genvar k = 0; k < NWORDS; k++) begin : g_word
    localparam int LSB = (NWORDS - 1 - k) * WORD_W;

    assign hit_data[k] = (addr_i == ADDR_W'(OFF_DATA0 + 8'(4 * k)));
    assign wr_entry_o[LSB +: WORD_W] = data_q[k];
    assign view[k] = ld_pend_q ? rd_entry_i[LSB +: WORD_W] : data_q[k];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    data_q[k] <= '0;
      else if (bus_wr && hit_data[k]) data_q[k] <= wdata_i;  // bus beats fetch
      else if (ld_pend_q)             data_q[k] <= rd_entry_i[LSB +: WORD_W];
    end

    a_r5_fetch_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ld_pend_q && !(bus_wr && hit_data[k])) |=> (data_q[k] == $past(rd_entry_i[LSB +: WORD_W])));

    a_r8_bus_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_wr && hit_data[k]) |=> (data_q[k] == $past(wdata_i)));
  end

  always_comb begin
    rdata_d = '0;
    if (addr_i == ADDR_W'(OFF_VER))       rdata_d = {16'h0, VER_MAJOR, VER_MINOR};
    else if (addr_i == ADDR_W'(OFF_SIZE)) rdata_d = {27'h0, SIZE_CODE};
    for (int k = 0; k < NWORDS; k++)
      if (hit_data[k]) rdata_d = view[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= bus_rd;
      rdata_q  <= bus_rd ? rdata_d : '0;
    end
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;

  a_r10_rd_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd |=> rvalid_o);

  a_r10_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd |=> !rvalid_o);

  a_r1_version: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd && addr_i == ADDR_W'(OFF_VER)) |=> (rdata_o[7:0] == VER_MINOR && rdata_o[15:8] == VER_MAJOR));
endmodule

// File: rtl/lap_top.sv
module lap_top
  import lap_pkg::*;
#(
  parameter int         DEPTH     = 64,
  parameter int         ADDR_W    = 8,
  parameter logic [7:0] VER_MAJOR = 8'h01,
  parameter logic [7:0] VER_MINOR = 8'h04
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic              rvalid_o,
  output logic [31:0]       rdata_o
);
  localparam int         SIZE_UNITS = (DEPTH >= 1024) ? DEPTH / 1024 : 0;
  localparam logic [4:0] SIZE_CODE  = 5'(SIZE_UNITS);

  logic   wr_en, clr;
  idx_t   wr_idx, rd_idx;
  entry_t wr_entry, rd_entry;

  lap_reg_if #(
    .ADDR_W(ADDR_W), .VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR), .SIZE_CODE(SIZE_CODE)
  ) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rvalid_o, .rdata_o,
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_entry_o(wr_entry),
    .rd_idx_o(rd_idx), .rd_entry_i(rd_entry), .clr_o(clr)
  );

  lap_table_store #(.DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_entry_i(wr_entry),
    .rd_idx_i(rd_idx), .rd_entry_o(rd_entry), .clr_i(clr)
  );
endmodule

// File: tb/lap_top_tb.sv
module lap_top_tb;
  localparam int DEPTH = 64;
  localparam logic [7:0] MAJ = 8'h01;
  localparam logic [7:0] MIN = 8'h04;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic rvalid;
  logic [31:0] rdata;

  int total = 0, bad = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  logic [95:0] model [DEPTH];
  logic [31:0] dw [3];

  always #5 clk = ~clk;

  lap_top #(.DEPTH(DEPTH), .ADDR_W(8), .VER_MAJOR(MAJ), .VER_MINOR(MIN)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rvalid_o(rvalid), .rdata_o(rdata));

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // monitor: pops the scoreboard as read data arrives
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) check("R10 unexpected rvalid", 32'h1, 32'h0);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic idle();
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    if (a >= 8'h34 && a <= 8'h3C) dw[(a - 8'h34) >> 2] = d;
  endtask

  task automatic bus_read(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
  endtask

  task automatic cmd_commit(int idx);
    bus_write(8'h20, 32'h8000_0000 | 32'(idx));
    if (idx < DEPTH) model[idx] = {dw[0], dw[1], dw[2]};
  endtask

  task automatic cmd_fetch(int idx);
    logic [95:0] e;
    bus_write(8'h20, 32'(idx) & 32'h7FFF_FFFF);
    e = (idx < DEPTH) ? model[idx] : '0;
    dw[0] = e[95:64]; dw[1] = e[63:32]; dw[2] = e[31:0];
  endtask

  task automatic read_words(string tag);
    for (int k = 0; k < 3; k++) bus_read(8'h34 + 8'(4 * k), dw[k], tag);
  endtask

  task automatic load_words(logic [31:0] a, logic [31:0] b, logic [31:0] c);
    bus_write(8'h34, a); bus_write(8'h38, b); bus_write(8'h3C, c);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset rvalid", {31'h0, rvalid}, 32'h0);
    check("R9 reset rdata", rdata, 32'h0);
    rst_n = 1'b1;
    dw[0] = '0; dw[1] = '0; dw[2] = '0;

    bus_read(8'h00, {16'h0, MAJ, MIN}, "R1 version");
    bus_read(8'h04, 32'h0, "R2 size code");
    read_words("R9 data words after reset");
    bus_write(8'h00, 32'hFFFF_FFFF);
    bus_write(8'h04, 32'hFFFF_FFFF);
    bus_read(8'h00, {16'h0, MAJ, MIN}, "R1 version after write");
    bus_read(8'h04, 32'h0, "R2 size after write");
    idle();

    load_words(32'hA5A5_0001, 32'h3000_00B2, 32'hC3C3_0003);
    read_words("R3 data readback");
    cmd_commit(5);
    load_words(32'h1111_1111, 32'h2222_2222, 32'h3333_3333);
    cmd_commit(0);
    load_words(32'hDEAD_BEEF, 32'hFFFF_FFFF, 32'h0123_4567);
    cmd_commit(DEPTH - 1);
    load_words(32'h0, 32'h1000_0000, 32'h8000_0001);
    cmd_commit(17);
    // fetch then read at once: forwarding path
    cmd_fetch(5);
    read_words("R5 fetch idx5 back-to-back");
    cmd_fetch(DEPTH - 1);
    read_words("R4 R5 fetch last idx");
    cmd_fetch(0);
    idle(); idle();
    read_words("R4 fetch idx0");
    // word order: a commit of known words then fetch returns same positions
    cmd_fetch(17);
    read_words("R4 word order idx17");
    idle();

    // out-of-range
    load_words(32'hBAD0_BAD0, 32'hBAD1_BAD1, 32'hBAD2_BAD2);
    cmd_commit(DEPTH);
    cmd_commit(DEPTH + 5);
    cmd_fetch(0);
    read_words("R6 oob commit ignored idx0");
    cmd_fetch(5);
    read_words("R6 oob commit ignored idx5");
    cmd_fetch(DEPTH);
    read_words("R6 oob fetch zero");
    cmd_fetch(32'h7FFF_FFFF);
    read_words("R6 oob fetch max zero");
    idle();

    // collision: data-word write in the load cycle
    cmd_fetch(DEPTH - 1);
    bus_write(8'h38, 32'h5555_AAAA);
    read_words("R8 bus write beats fetch");
    idle();

    // clear with a fetch pending in the same cycle
    cmd_fetch(17);
    bus_write(8'h08, 32'h4000_0000);
    for (int i = 0; i < DEPTH; i++) model[i][61:60] = 2'b00;
    bus_read(8'h08, 32'h0, "R7 control reads zero");
    cmd_fetch(17);
    read_words("R7 clear keeps other bits idx17");
    cmd_fetch(DEPTH - 1);
    read_words("R7 clear idx last");
    cmd_fetch(5);
    read_words("R7 clear idx5");

    bus_read(8'h20, 32'h0, "R10 table control reads zero");
    bus_read(8'h40, 32'h0, "R10 unmapped 0x40");
    bus_read(8'h10, 32'h0, "R10 unmapped 0x10");
    idle(); idle(); idle();
    check("R10 all reads answered", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog got=hung exp=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule